// File: doc/BRIEF.md
# Strip Hit Capture and Daisy-Chain Serial Readout

This block is the digital front-end for one plane of detector strips. Its strip inputs are the discriminator outputs, already synchronous to the block clock. A trigger strobe captures the hit state of every strip into a shift word. Single-cycle shift ticks then move the captured word out one bit at a time.

Boards are daisy-chained. The serial output of one board drives the chain input of the next board. The readout therefore collects 32 bits per board per event, with the board farthest from the readout arriving last. Shifting continues for as long as ticks arrive, so the bits from upstream boards pass through this board.

Two further functions run alongside the capture path. A selectable strip is copied to a monitor line, which feeds an external noise-rate counter. The plane trigger is formed from the live strips in two forms: a timing output that is high when any strip is hit, and a multiplicity output that is high when a run of m adjacent strips is hit, with m set from 1 to 4.

Top module: `strip_frontend`

## Requirements
- R1: After reset, all outputs are low and the shift word holds all zeros.
- R2: A latch strobe that is accepted loads the strip inputs into the shift word. On the next cycle, `ser_o` shows strip 0.
- R3: Each shift tick moves the word one place toward bit 0, and `chain_i` enters at bit 31. After k ticks, `ser_o` shows the bit captured from strip k. After 32 ticks, it shows the chain bits in the order they arrived.
- R4: Once a strobe has been accepted, further strobes are ignored until 32 shift ticks have occurred. While strobes are being ignored, the word changes only on shift ticks.
- R5: When a strobe is accepted in the same cycle as a shift tick, the load takes priority and the tick has no effect.
- R6: Ticks after the 32nd keep passing chain bits through to `ser_o`.
- R7: `mon_o` equals the strip selected by the 5-bit `mon_sel_i` index, one cycle later.
- R8: `any_hit_o` is high one cycle after any strip input is high.
- R9: `fold_hit_o` is high one cycle after at least one window of m adjacent strips is all hit. The value m is `fold_i` + 1, so `fold_i` = 0 selects m = 1 and `fold_i` = 3 selects m = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_i | input | 32 | Strip hit lines, synchronous |
| latch_i | input | 1 | Trigger strobe that captures the strips |
| shift_i | input | 1 | Shift tick, one bit per cycle when high |
| chain_i | input | 1 | Serial input from the upstream board |
| mon_sel_i | input | 5 | Index of the strip sent to the monitor |
| fold_i | input | 2 | Multiplicity setting, m = fold_i + 1 |
| ser_o | output | 1 | Serial data toward the readout |
| mon_o | output | 1 | Registered copy of the selected strip |
| any_hit_o | output | 1 | High when any strip is hit (timing stop) |
| fold_hit_o | output | 1 | High when m adjacent strips are hit |

## Verification
A wrong bit in the shift word reaches `ser_o` after as many ticks as its position. The bench therefore compares the serial output on every cycle against a queue model, which catches a corrupted bit by the tick that exposes it.

A wrong value in the lock-out counter has two possible effects. It can let a strobe overwrite a word that is half shifted out, which misplaces bits on the next tick. It can also block a strobe that should have been accepted, which leaves old or chain bits on `ser_o` where fresh strips were expected.

The monitor and trigger outputs carry no internal state beyond one register stage. A fault in them shows up one cycle after the input pattern that exposes it.

// File: rtl/strip_frontend.sv
module strip_frontend #(
  parameter int NSTRIP = 32,
  parameter int MAXF   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSTRIP-1:0]         strip_i,
  input  logic                      latch_i,
  input  logic                      shift_i,
  input  logic                      chain_i,
  input  logic [$clog2(NSTRIP)-1:0] mon_sel_i,
  input  logic [$clog2(MAXF)-1:0]   fold_i,
  output logic                      ser_o,
  output logic                      mon_o,
  output logic                      any_hit_o,
  output logic                      fold_hit_o
);
  localparam int CW = $clog2(NSTRIP + 1);

  logic [NSTRIP-1:0] word_q;
  logic [CW-1:0]     pend_q;
  logic              load;
  logic              fold_d;
  logic              win;
  logic [NSTRIP+MAXF-2:0] padded;

  assign load   = latch_i && (pend_q == '0);
  assign ser_o  = word_q[0];
  assign padded = {{(MAXF-1){1'b0}}, strip_i};

  always_comb begin
    fold_d = 1'b0;
    for (int i = 0; i < NSTRIP; i++) begin
      win = 1'b1;
      for (int j = 0; j < MAXF; j++)
        if (j <= int'(fold_i)) win = win & padded[i+j];
      fold_d = fold_d | win;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q     <= '0;
      pend_q     <= '0;
      mon_o      <= 1'b0;
      any_hit_o  <= 1'b0;
      fold_hit_o <= 1'b0;
    end else begin
      if (load) begin
        word_q <= strip_i;
        pend_q <= CW'(NSTRIP);
      end else if (shift_i) begin
        word_q <= {chain_i, word_q[NSTRIP-1:1]};
        if (pend_q != '0) pend_q <= pend_q - 1'b1;
      end
      mon_o      <= strip_i[mon_sel_i];
      any_hit_o  <= |strip_i;
      fold_hit_o <= fold_d;
    end
  end
endmodule

// File: rtl/strip_frontend_chk.sv
module strip_frontend_chk #(
  parameter int NSTRIP = 32,
  parameter int MAXF   = 4,
  parameter int CW     = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NSTRIP-1:0]         strip_i,
  input logic                      latch_i,
  input logic                      shift_i,
  input logic                      chain_i,
  input logic [$clog2(NSTRIP)-1:0] mon_sel_i,
  input logic                      ser_o,
  input logic                      mon_o,
  input logic                      any_hit_o,
  input logic                      fold_hit_o,
  input logic [NSTRIP-1:0]         word,
  input logic [CW-1:0]             pend
);
  assert_load_captures_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_i && pend == '0) |=> (word == $past(strip_i)));

  assert_chain_enters_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !(latch_i && pend == '0)) |=> (word[NSTRIP-1] == $past(chain_i)));

  assert_locked_word_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0 && !shift_i) |=> $stable(word));

  assert_pend_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= CW'(NSTRIP));

  assert_monitor_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mon_o == $past(strip_i[mon_sel_i])));

  assert_fold_needs_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fold_hit_o |-> any_hit_o);

  assert_any_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (any_hit_o == ($past(strip_i) != '0)));
endmodule

bind strip_frontend strip_frontend_chk #(.NSTRIP(NSTRIP), .MAXF(MAXF), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .strip_i(strip_i), .latch_i(latch_i),
  .shift_i(shift_i), .chain_i(chain_i), .mon_sel_i(mon_sel_i),
  .ser_o(ser_o), .mon_o(mon_o), .any_hit_o(any_hit_o),
  .fold_hit_o(fold_hit_o), .word(word_q), .pend(pend_q)
);

// File: tb/strip_frontend_tb.sv
module strip_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strip_i = '0;
  logic        latch_i = 1'b0, shift_i = 1'b0, chain_i = 1'b0;
  logic [4:0]  mon_sel_i = '0;
  logic [1:0]  fold_i = '0;
  logic        ser_o, mon_o, any_hit_o, fold_hit_o;

  int total = 0, failed = 0;
  bit done = 0;
  bit q[$];
  int lock = 0;

  always #10 clk = ~clk;

  strip_frontend dut_i (.*);

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ref_fold(logic [31:0] s, int m);
    int run = 0;
    for (int i = 0; i < 32; i++) begin
      run = s[i] ? run + 1 : 0;
      if (run >= m) return 1;
    end
    return 0;
  endfunction

  task automatic step(logic [31:0] s, bit lat, bit sh, bit ch, int sel, int fo);
    logic [31:0] s_prev;
    int sel_prev, fo_prev;
    strip_i = s; latch_i = lat; shift_i = sh; chain_i = ch;
    mon_sel_i = 5'(sel); fold_i = 2'(fo);
    s_prev = s; sel_prev = sel; fo_prev = fo;
    @(posedge clk);
    if (lat && lock == 0) begin
      q = {};
      for (int i = 0; i < 32; i++) q.push_back(s_prev[i]);
      lock = 32;
    end else if (sh) begin
      void'(q.pop_front());
      q.push_back(ch);
      if (lock > 0) lock--;
    end
    @(negedge clk);
    check("R2/R3/R4/R5/R6 ser_o", ser_o, q[0]);
    check("R7 mon_o", mon_o, s_prev[sel_prev]);
    check("R8 any_hit_o", any_hit_o, s_prev != 0);
    check("R9 fold_hit_o", fold_hit_o, ref_fold(s_prev, fo_prev + 1));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb;
    for (int i = 0; i < 32; i++) q.push_back(1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ser_o", ser_o, 1'b0);
    check("R1 mon_o", mon_o, 1'b0);
    check("R1 any_hit_o", any_hit_o, 1'b0);
    check("R1 fold_hit_o", fold_hit_o, 1'b0);

    pa = 32'hA5C3_0F96;
    pb = 32'h1234_FEDC;
    step(pa, 1, 0, 0, 3, 0);                                  // R2
    for (int k = 0; k < 10; k++) step('0, 0, 1, k[0], k, 1);  // R3
    step(pb, 1, 0, 0, 7, 2);                                  // R4 ignored
    step(pb, 1, 1, 1, 8, 3);                                  // R4 ignored, shifts
    for (int k = 0; k < 21; k++) step('0, 0, 1, k[1], k, 0);
    step(pb, 1, 1, 1, 31, 1);                                 // R5 load wins
    for (int k = 0; k < 40; k++) step(pb >> k, 0, 1, k[2] ^ k[0], k, k % 4); // R6
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom() & $urandom();
      step(r, ($urandom_range(0, 19) == 0), $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 31), $urandom_range(0, 3));
    end
    step(32'h0000_0F00, 0, 0, 0, 8, 3);                       // R9 run of 4
    step(32'h0000_0700, 0, 0, 0, 9, 3);                       // R9 run of 3 only
    step(32'h8000_0000, 0, 0, 0, 31, 0);                      // R8 top strip
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule